// File: doc/BRIEF.md
# Two-Phase Handshaked Register Pipeline

This block is a chain of single-word register stages. Neighbouring stages capture on opposite edges of one clock. Each stage sends a valid flag forward beside its data word. Each stage also sends an accept flag backward, and that flag says the stage stored a word at its most recent capture edge. A stage sees its downstream neighbour's flag half a clock period after the neighbour's edge, and half a period before its own next edge. Because of this, a word can be handed over and acknowledged within one clock cycle. The chain moves one word per cycle, stops the moment the sink holds off, and restarts with no bubble. It needs no skid storage.

Back pressure works as follows. A stage's register loads only when its input is valid and the stage is free. A stage is free when it is empty, or when its downstream neighbour took its current word at the edge in between. In every other case the register keeps its value, so its load enable doubles as a clock-gating condition.

The two neighbours outside the chain must follow the same rules as a stage:
- The source changes `s_valid`/`s_data` only on the edge opposite to stage 0. It treats `s_accept` high as consumption of the word it presented.
- The sink captures on the edge opposite to the last stage. It drives `m_accept` as a registered flag that means "took a word at my last edge".

Top module: `alt_edge_pipe`

## Requirements
- R1: When `rst_n` is low (asynchronous, active low), every stage is empty and every accept flag is clear: `m_valid` = 0 and `s_accept` = 0.
- R2: Stage i captures on the rising edge when (i even) equals `FIRST_RISE`, and on the falling edge otherwise. With the defaults (`FIRST_RISE`=1, `STAGES`=4), `s_accept` changes only after rising edges, and `m_valid`/`m_data` change only after falling edges.
- R3: A stage loads its input only when the input is valid and the stage is empty or has just been drained downstream. A full chain whose sink never accepts keeps `s_accept` at 0.
- R4: A stage's accept flag is registered at its own edge and is high exactly when the stage stored a word at that edge. `s_accept` can be high only if `s_valid` was high at the previous stage-0 edge.
- R5: While the last stage holds a word that the sink has not accepted, `m_valid` stays 1 and `m_data` stays unchanged.
- R6: When the source is always valid and the sink always accepts, one word leaves per clock cycle.
- R7: When the source is always valid, a sink that stalls and then resumes finds `m_valid` high at every one of its edges once the chain has filled, so a restart adds no bubble.
- R8: Words leave in the order they were accepted, with none lost and none repeated, under any pattern of source and sink stalls.
- R9: Each stage holds exactly one word. With the sink stalled, the chain absorbs exactly `STAGES` words.
- R10: The data path is `DATA_W` bits wide (default 32), and every bit is carried unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock; stages alternate between its two edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Source word present |
| s_data | input | DATA_W | Source word |
| s_accept | output | 1 | Stage 0 stored a word at its last edge |
| m_valid | output | 1 | Last stage holds a word |
| m_data | output | DATA_W | Word held by the last stage |
| m_accept | input | 1 | Sink stored the word at its last edge |

## Verification
Four checks run on every clock edge:
- the empty state under reset;
- that an input acknowledge always follows a valid word;
- that an unaccepted output word is held steady;
- that the number of words leaving never exceeds the number accepted.

Some behaviour only shows across a whole scenario, and the bench's scenarios cover it. These are the phase of each port change relative to the clock, exact ordering and duplicate-freedom over long random stall patterns, one-word-per-cycle flow, the absence of a bubble after a sink stall, and the fill count of a blocked chain.

// File: rtl/alt_edge_pipe_pkg.sv
package alt_edge_pipe_pkg;

  // Capture edge of stage idx: 1 = rising, 0 = falling. Neighbours differ.
  function automatic bit stage_rises(input bit first_rise, input int idx);
    return first_rise ^ idx[0];
  endfunction

endpackage

// File: rtl/alt_hs_ctrl.sv
// Handshake decision for one stage, evaluated just before its capture edge.
module alt_hs_ctrl (
  input  logic own_valid,
  input  logic dn_accept,
  input  logic up_valid,
  output logic load_en,
  output logic next_valid
);
  logic drained;
  logic free;

  always_comb begin
    drained    = own_valid & dn_accept;
    free       = ~own_valid | drained;
    load_en    = up_valid & free;
    next_valid = load_en | (own_valid & ~drained);
  end
endmodule

// File: rtl/alt_hs_stage.sv
module alt_hs_stage #(
  parameter int DATA_W = 32,
  parameter bit RISE   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  input  logic [DATA_W-1:0] up_data,
  output logic              up_accept,
  output logic              dn_valid,
  output logic [DATA_W-1:0] dn_data,
  input  logic              dn_accept
);
  logic              valid_q;
  logic              acc_q;
  logic [DATA_W-1:0] data_q;
  logic              load_en;
  logic              next_valid;

  alt_hs_ctrl u_ctrl (
    .own_valid (valid_q),
    .dn_accept (dn_accept),
    .up_valid  (up_valid),
    .load_en   (load_en),
    .next_valid(next_valid)
  );

  if (RISE) begin : g_rise
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q <= 1'b0;
        acc_q   <= 1'b0;
      end else begin
        valid_q <= next_valid;
        acc_q   <= load_en;
      end
    end
    always_ff @(posedge clk) begin
      if (load_en) data_q <= up_data;
    end
  end else begin : g_fall
    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q <= 1'b0;
        acc_q   <= 1'b0;
      end else begin
        valid_q <= next_valid;
        acc_q   <= load_en;
      end
    end
    always_ff @(negedge clk) begin
      if (load_en) data_q <= up_data;
    end
  end

  assign up_accept = acc_q;
  assign dn_valid  = valid_q;
  assign dn_data   = data_q;
endmodule

// File: rtl/alt_edge_pipe.sv
module alt_edge_pipe
  import alt_edge_pipe_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int STAGES     = 4,
  parameter bit FIRST_RISE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  output logic              s_accept,
  output logic              m_valid,
  output logic [DATA_W-1:0] m_data,
  input  logic              m_accept
);
  localparam int LINKS = STAGES + 1;

  logic              vld [LINKS];
  logic [DATA_W-1:0] dat [LINKS];
  logic              acc [LINKS];

  assign vld[0]      = s_valid;
  assign dat[0]      = s_data;
  assign acc[STAGES] = m_accept;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    alt_hs_stage #(
      .DATA_W(DATA_W),
      .RISE  (stage_rises(FIRST_RISE, i))
    ) u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .up_valid (vld[i]),
      .up_data  (dat[i]),
      .up_accept(acc[i]),
      .dn_valid (vld[i+1]),
      .dn_data  (dat[i+1]),
      .dn_accept(acc[i+1])
    );
  end

  assign s_accept = acc[0];
  assign m_valid  = vld[STAGES];
  assign m_data   = dat[STAGES];
endmodule

// File: rtl/alt_edge_pipe_chk.sv
module alt_edge_pipe_chk
  import alt_edge_pipe_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int STAGES     = 4,
  parameter bit FIRST_RISE = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_valid,
  input logic [DATA_W-1:0] s_data,
  input logic              s_accept,
  input logic              m_valid,
  input logic [DATA_W-1:0] m_data,
  input logic              m_accept
);
  localparam bit LAST_RISE = stage_rises(FIRST_RISE, STAGES - 1);

  int unsigned cnt_in;
  int unsigned cnt_out;

  AST_RESET_EMPTY: assert property (@(posedge clk) !rst_n |-> (!m_valid && !s_accept)) else $error("reset state"); // R1

  if (FIRST_RISE) begin : g_in_rise
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_in <= 0;
      else if (s_accept) cnt_in <= cnt_in + 1;
    end
    AST_ACCEPT_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n) s_accept |-> $past(s_valid)) else $error("accept without valid"); // R4
  end else begin : g_in_fall
    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) cnt_in <= 0;
      else if (s_accept) cnt_in <= cnt_in + 1;
    end
    AST_ACCEPT_AFTER_VALID: assert property (@(negedge clk) disable iff (!rst_n) s_accept |-> $past(s_valid)) else $error("accept without valid"); // R4
  end

  if (LAST_RISE) begin : g_out_rise
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_out <= 0;
      else if (m_accept) cnt_out <= cnt_out + 1;
    end
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (m_valid && !m_accept) |=> (m_valid && $stable(m_data))) else $error("output not held"); // R5
    AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (!rst_n) cnt_out <= cnt_in) else $error("word created"); // R8
  end else begin : g_out_fall
    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) cnt_out <= 0;
      else if (m_accept) cnt_out <= cnt_out + 1;
    end
    AST_OUT_HOLD: assert property (@(negedge clk) disable iff (!rst_n) (m_valid && !m_accept) |=> (m_valid && $stable(m_data))) else $error("output not held"); // R5
    AST_NO_PHANTOM: assert property (@(negedge clk) disable iff (!rst_n) cnt_out <= cnt_in) else $error("word created"); // R8
  end
endmodule

bind alt_edge_pipe alt_edge_pipe_chk #(
  .DATA_W    (DATA_W),
  .STAGES    (STAGES),
  .FIRST_RISE(FIRST_RISE)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .s_valid (s_valid),
  .s_data  (s_data),
  .s_accept(s_accept),
  .m_valid (m_valid),
  .m_data  (m_data),
  .m_accept(m_accept)
);

// File: tb/tb_alt_edge_pipe.sv
`timescale 1ns/1ps
module tb_alt_edge_pipe;
  localparam int DATA_W = 32;
  localparam int STAGES = 4;
  // Defaults: stage 0 rising, stage 3 falling -> source on falling edge, sink on rising edge.

  logic              clk = 1'b0;
  logic              rst_n = 1'b1;
  logic              s_valid = 1'b0;
  logic [DATA_W-1:0] s_data = '0;
  logic              s_accept;
  logic              m_valid;
  logic [DATA_W-1:0] m_data;
  logic              m_accept = 1'b0;

  always #2 clk = ~clk;

  alt_edge_pipe #(.DATA_W(DATA_W), .STAGES(STAGES), .FIRST_RISE(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data), .s_accept(s_accept),
    .m_valid(m_valid), .m_data(m_data), .m_accept(m_accept)
  );

  int vectors = 0;
  int miscompares = 0;
  logic [DATA_W-1:0] exp_q [$];
  int src_mode = 2;   // 0 always, 1 random, 2 never
  int snk_mode = 2;
  int src_budget = 0;
  int unsigned seq = 0;
  int n_acc = 0;
  int n_out = 0;
  bit bubble_chk = 1'b0;
  int edge_viol = 0;
  bit rst_hit = 1'b0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit decide(input int mode, input int pct);
    if (mode == 0) return 1'b1;
    if (mode == 1) return ($urandom % 100) < pct;
    return 1'b0;
  endfunction

  function automatic logic [DATA_W-1:0] mk(input int unsigned n);
    return {~n[15:0] ^ 16'h5A00, n[15:0]};
  endfunction

  // Source: behaves as a stage capturing on the falling edge.
  initial forever begin
    @(negedge clk);
    if (!rst_n) s_valid = 1'b0;
    else begin
      if (s_valid && s_accept) begin
        exp_q.push_back(s_data);
        n_acc++;
        s_valid = 1'b0;
      end
      if (!s_valid && src_budget > 0 && decide(src_mode, 55)) begin
        s_data = mk(seq);
        seq++;
        src_budget--;
        s_valid = 1'b1;
      end
    end
  end

  // Sink and scoreboard monitor: behaves as a stage capturing on the rising edge.
  initial forever begin
    @(posedge clk);
    if (!rst_n) m_accept = 1'b0;
    else begin
      bit take;
      if (bubble_chk && !m_valid)
        check(1'b0, "R7 bubble at sink edge", {31'd0, m_valid}, 32'd1);
      take = m_valid && decide(snk_mode, 60);
      if (take) begin
        if (exp_q.size() == 0) check(1'b0, "R8 unexpected word", m_data, '0);
        else begin
          logic [DATA_W-1:0] e;
          e = exp_q.pop_front();
          check(m_data === e, "R8/R10 order and data", m_data, e);
        end
        n_out++;
      end
      m_accept = take;
    end
  end

  // Edge-phase monitor for R2.
  always @(negedge rst_n) rst_hit = 1'b1;
  initial begin
    logic sa;
    logic mv;
    logic [DATA_W-1:0] md;
    bit have;
    have = 1'b0;
    forever begin
      @(posedge clk); #1;
      if (have && !rst_hit && (m_valid !== mv || m_data !== md)) edge_viol++;
      rst_hit = 1'b0;
      sa = s_accept;
      @(negedge clk); #1;
      if (!rst_hit && s_accept !== sa) edge_viol++;
      mv = m_valid; md = m_data; have = 1'b1;
    end
  end

  task automatic do_reset();
    @(posedge clk); #2;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(!m_valid && !s_accept, "R1 reset state", {30'd0, m_valid, s_accept}, '0);
    exp_q.delete();
    n_acc = 0;
    n_out = 0;
    #1 rst_n = 1'b1;
  endtask

  task automatic drain();
    snk_mode = 0;
    for (int k = 0; k < 20000 && !(src_budget == 0 && !s_valid && exp_q.size() == 0 && !m_valid); k++)
      @(posedge clk);
    #1;
    check(exp_q.size() == 0, "R8 all words delivered", exp_q.size(), 0);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int base;
    logic [DATA_W-1:0] held;
    do_reset();

    // R6: full rate
    src_mode = 0; snk_mode = 0; src_budget = 100;
    for (int k = 0; k < 200 && n_out == 0; k++) @(posedge clk);
    #1 base = n_out;
    repeat (40) @(posedge clk);
    #1 check(n_out - base == 40, "R6 one word per cycle", n_out - base, 40);
    drain();

    // R9, R3, R5: blocked sink
    src_mode = 2; snk_mode = 2;
    do_reset();
    src_mode = 0; src_budget = 50;
    repeat (30) @(posedge clk);
    #1;
    check(n_acc == STAGES, "R9 chain capacity", n_acc, STAGES);
    check(!s_accept, "R3 no load when full", {31'd0, s_accept}, '0);
    check(m_valid && m_data === exp_q[0], "R5 head word presented", m_data, exp_q[0]);
    held = m_data;
    repeat (10) @(posedge clk);
    #1 check(m_valid && m_data === held, "R5 held while unaccepted", m_data, held);
    check(n_acc == STAGES, "R3 capacity unchanged under stall", n_acc, STAGES);
    drain();

    // R8: random stalls on both sides
    src_mode = 1; snk_mode = 1; src_budget = 1500;
    for (int k = 0; k < 20000 && src_budget > 0; k++) @(posedge clk);
    drain();

    // R7: sink stalls with a saturated source
    src_mode = 0; snk_mode = 1; src_budget = 100000;
    repeat (20) @(posedge clk);
    #1 bubble_chk = 1'b1;
    base = vectors;
    repeat (1500) @(posedge clk);
    #1 bubble_chk = 1'b0;
    check(vectors > base, "R7 restarts exercised", vectors - base, 1);
    src_budget = 0;
    drain();

    check(edge_viol == 0, "R2 edge phase of port changes", edge_viol, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule